// File: doc/BRIEF.md
# Address Entry Slot Allocator

This block chooses the slot of an address lookup table where a new or updated address entry should be written. A client pulses `start` with a 48-bit MAC address. The block then walks the table one slot per clock through a simple read port. It walks in ascending index order and makes at most three passes, each with a narrower aim:

- The first pass looks for an address entry whose stored MAC equals the key.
- The second pass looks for an unused slot.
- The third pass looks for a unicast entry that may be evicted.

Each pass stops at its first hit. If all three passes finish without a hit, the block reports that the table is full.

The table storage stays outside the block. For the slot named on `rd_idx`, the storage returns two things in the same cycle. The first is the entry's upper control nibble, which is entry bits 63:60. The second is its 48-bit address field, which is entry bits 47:0. The VLAN field and the per-entry flag bits above bit 63 (secure, blocked and owner port) play no part in the choice, so they are not brought in. Writing the entry is left to the client, which uses `slot_idx` and `slot_src`.

Top module: `slot_alloc`

## Requirements
- R1: After reset, `busy`, `done` and `found` are 0, `slot_src` is 0 and `slot_idx` is 0.
- R2: A `start` sampled while idle captures `mac_key` and raises `busy` on the next cycle, with `rd_idx` at 0. The scan then advances `rd_idx` by one per cycle.
- R3: Pass 1 hits on an entry whose type (`rd_ctl[1:0]`, entry bits 61:60) is 1 (address) or 3 (VLAN plus address) and whose `rd_mac` equals the key. The MAC is stored with the first byte in bits 47:40. Such a hit reports `slot_src` = 1. Types 0 and 2 never match, even with equal address bits.
- R4: When no entry matches, pass 2 reports the lowest-index entry of type 0 (free), with `slot_src` = 2.
- R5: When neither match nor free slot exists, pass 3 reports the lowest-index entry of type 1 or 3 that meets two conditions, with `slot_src` = 3. Its address bit 40 (multicast flag) must be clear. Its unicast type (`rd_ctl[3:2]`, entry bits 63:62) must be 1 (untouched) or 3 (touched). Types 0 (persistent) and 2 (OUI) are never evicted.
- R6: When no pass hits, `done` pulses with `found` = 0 and `slot_src` = 0.
- R7: A hit at index i in pass p (1..3) raises `done` exactly (p-1)*ENTRIES + i + 1 cycles after the edge that sampled `start`. A full table raises `done` after 3*ENTRIES cycles.
- R8: A `start` pulse while `busy` is high is ignored. The key, the result and the timing stay those of the running search.
- R9: `done` is high for one cycle. `found`, `slot_idx` and `slot_src` hold their values until the next search completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a search with `mac_key` (ignored while busy) |
| mac_key | input | 48 | Address to place |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle completion pulse |
| found | output | 1 | A slot qualified |
| slot_idx | output | IDX_W | Chosen slot index |
| slot_src | output | 2 | 0 none, 1 match, 2 free, 3 evict |
| rd_idx | output | IDX_W | Table slot being read |
| rd_ctl | input | 4 | Entry bits 63:60 of slot `rd_idx` |
| rd_mac | input | 48 | Entry bits 47:0 of slot `rd_idx` |

## Verification
The assertions check several properties on every cycle:
- the pulse shape of `done`;
- the agreement between `found` and `slot_src`;
- the entry into a scan at index 0;
- that the captured key stays unchanged under a stray `start`;
- that a free decode never coincides with a match or eviction decode.

Only the bench scenarios can show which slot wins and when. These scenarios cover the lowest-index choice, the strict order of the three passes, the protection of persistent, OUI and multicast entries, and the exact completion latency. The bench compares each result against a reference search over a modelled table.

// File: rtl/slot_alloc_pkg.sv
// Shared types for the slot allocator.
// Assumes: result codes double as the pass identifier during a scan.
package slot_alloc_pkg;
    localparam int MAC_W = 48;
    localparam int CTL_W = 4;

    typedef enum logic [1:0] {
        SRC_NONE  = 2'd0,
        SRC_MATCH = 2'd1,
        SRC_FREE  = 2'd2,
        SRC_EVICT = 2'd3
    } src_e;

    localparam logic [1:0] TYPE_FREE   = 2'd0;
    localparam logic [1:0] TYPE_ADDR   = 2'd1;
    localparam logic [1:0] TYPE_VADDR  = 2'd3;
    localparam logic [1:0] UC_UNTOUCH  = 2'd1;
    localparam logic [1:0] UC_TOUCHED  = 2'd3;
    localparam int         MCAST_BIT   = 40;
endpackage

// File: rtl/slot_entry_decode.sv
// Decodes one table entry against the search key.
// Assumes: ctl = entry bits 63:60 (unicast type in [3:2], entry type in [1:0]),
// mac = entry bits 47:0 with bit 40 as the multicast flag. Purely combinational.
module slot_entry_decode
    import slot_alloc_pkg::*;
(
    input  logic [CTL_W-1:0] ctl,
    input  logic [MAC_W-1:0] mac,
    input  logic [MAC_W-1:0] key,
    output logic             is_match,
    output logic             is_free,
    output logic             is_evict
);
    logic [1:0] etype;
    logic [1:0] utype;
    logic       addr_kind;

    // Field split and per-pass qualification.
    always_comb begin
        etype     = ctl[1:0];
        utype     = ctl[3:2];
        addr_kind = (etype == TYPE_ADDR) || (etype == TYPE_VADDR);
        is_match  = addr_kind && (mac == key);
        is_free   = (etype == TYPE_FREE);
        is_evict  = addr_kind && !mac[MCAST_BIT] &&
                    ((utype == UC_UNTOUCH) || (utype == UC_TOUCHED));
    end

    // A free slot can never qualify for the other two passes (R4).
    always_comb begin
        assert_free_excl_R4: assert (!(is_free && (is_match || is_evict)));
    end
endmodule

// File: rtl/slot_scan_ctrl.sv
// Scan controller: walks indices 0..ENTRIES-1 once per pass, up to three
// passes (match, free, evict), stopping at the first hit.
// Assumes: hit_* reflect the entry at rd_idx in the same cycle.
module slot_scan_ctrl
    import slot_alloc_pkg::*;
#(
    parameter int ENTRIES = 16,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             hit_match,
    input  logic             hit_free,
    input  logic             hit_evict,
    output logic             busy,
    output logic             done,
    output logic             found,
    output logic [IDX_W-1:0] slot_idx,
    output src_e             slot_src,
    output logic [IDX_W-1:0] rd_idx
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

    src_e             pass_q;
    logic [IDX_W-1:0] idx_q;
    logic             hit;

    // Select the qualifier of the pass in progress.
    always_comb begin
        unique case (pass_q)
            SRC_MATCH: hit = hit_match;
            SRC_FREE:  hit = hit_free;
            SRC_EVICT: hit = hit_evict;
            default:   hit = 1'b0;
        endcase
    end

    // Scan state, pass sequencing and result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy     <= 1'b0;
            done     <= 1'b0;
            found    <= 1'b0;
            slot_idx <= '0;
            slot_src <= SRC_NONE;
            pass_q   <= SRC_NONE;
            idx_q    <= '0;
        end else begin
            done <= 1'b0;
            if (!busy) begin
                if (start) begin
                    busy   <= 1'b1;
                    pass_q <= SRC_MATCH;
                    idx_q  <= '0;
                end
            end else if (hit) begin
                busy     <= 1'b0;
                done     <= 1'b1;
                found    <= 1'b1;
                slot_idx <= idx_q;
                slot_src <= pass_q;
            end else if (idx_q == LAST) begin
                idx_q <= '0;
                if (pass_q == SRC_EVICT) begin
                    busy     <= 1'b0;
                    done     <= 1'b1;
                    found    <= 1'b0;
                    slot_idx <= '0;
                    slot_src <= SRC_NONE;
                end else begin
                    pass_q <= src_e'(pass_q + 2'd1);
                end
            end else begin
                idx_q <= idx_q + 1'b1;
            end
        end
    end

    assign rd_idx = idx_q;

    // done is a single-cycle pulse (R9).
    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // An accepted start opens a scan at index 0 (R2).
    assert_scan_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> (busy && rd_idx == '0 && !done));

    // A failed search carries the none code (R6).
    assert_fail_code_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !found) |-> (slot_src == SRC_NONE));

    // A successful search names its pass (R3).
    assert_found_code_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (done && found) |-> (slot_src != SRC_NONE));

    // Completion drops busy in the same cycle (R7).
    assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
endmodule

// File: rtl/slot_alloc.sv
// Top of the slot allocator: key capture, entry decode, scan control.
// Assumes: table storage answers rd_idx combinationally with entry bits
// 63:60 on rd_ctl and bits 47:0 on rd_mac.
module slot_alloc
    import slot_alloc_pkg::*;
#(
    parameter int ENTRIES = 16,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [47:0]      mac_key,
    output logic             busy,
    output logic             done,
    output logic             found,
    output logic [IDX_W-1:0] slot_idx,
    output logic [1:0]       slot_src,
    output logic [IDX_W-1:0] rd_idx,
    input  logic [3:0]       rd_ctl,
    input  logic [47:0]      rd_mac
);
    logic [MAC_W-1:0] key_q;
    logic             m_hit;
    logic             f_hit;
    logic             e_hit;
    src_e             src_w;

    // Capture the key only when a search is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n)
            key_q <= '0;
        else if (start && !busy)
            key_q <= mac_key;
    end

    slot_entry_decode u_dec (
        .ctl      (rd_ctl),
        .mac      (rd_mac),
        .key      (key_q),
        .is_match (m_hit),
        .is_free  (f_hit),
        .is_evict (e_hit)
    );

    slot_scan_ctrl #(.ENTRIES(ENTRIES)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .hit_match (m_hit),
        .hit_free  (f_hit),
        .hit_evict (e_hit),
        .busy      (busy),
        .done      (done),
        .found     (found),
        .slot_idx  (slot_idx),
        .slot_src  (src_w),
        .rd_idx    (rd_idx)
    );

    assign slot_src = src_w;

    // A start during a search leaves the captured key alone (R8).
    assert_ignore_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> $stable(key_q));
endmodule

// File: tb/slot_alloc_bench.sv
`timescale 1ns/1ps
module slot_alloc_bench;
    localparam int N  = 16;
    localparam int IW = $clog2(N);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [47:0]   mac_key = '0;
    logic          busy, done, found;
    logic [IW-1:0] slot_idx, rd_idx;
    logic [1:0]    slot_src;
    logic [3:0]    rd_ctl;
    logic [47:0]   rd_mac;

    logic [3:0]    t_ctl [N];
    logic [47:0]   t_mac [N];
    logic [47:0]   pool [4];

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    assign rd_ctl = t_ctl[rd_idx];
    assign rd_mac = t_mac[rd_idx];

    slot_alloc #(.ENTRIES(N)) u_slot_alloc (
        .clk(clk), .rst_n(rst_n), .start(start), .mac_key(mac_key),
        .busy(busy), .done(done), .found(found), .slot_idx(slot_idx),
        .slot_src(slot_src), .rd_idx(rd_idx), .rd_ctl(rd_ctl), .rd_mac(rd_mac)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    function automatic bit qualifies(input int i, input int p, input logic [47:0] k);
        logic [1:0] t = t_ctl[i][1:0];
        logic [1:0] u = t_ctl[i][3:2];
        bit addr = (t == 2'd1) || (t == 2'd3);
        case (p)
            1: return addr && (t_mac[i] == k);
            2: return t == 2'd0;
            default: return addr && !t_mac[i][40] && (u == 2'd1 || u == 2'd3);
        endcase
    endfunction

    task automatic ref_pick(input logic [47:0] k, output int idx, output int src, output int lat);
        idx = 0; src = 0; lat = 3 * N;
        for (int p = 1; p <= 3; p++) begin
            for (int i = 0; i < N; i++) begin
                if (src == 0 && qualifies(i, p, k)) begin
                    idx = i; src = p; lat = (p - 1) * N + i + 1;
                end
            end
            if (src != 0) break;
        end
    endtask

    task automatic lookup(input logic [47:0] k, input bit poke, input logic [47:0] pk,
                          input string tag);
        int eidx, esrc, elat, cnt;
        int hidx, hsrc;
        ref_pick(k, eidx, esrc, elat);
        @(negedge clk);
        mac_key = k; start = 1'b1;
        @(negedge clk);
        start = 1'b0; mac_key = pk;
        cnt = 0;
        if (elat > 0) begin
            check(busy == 1'b1 && rd_idx == '0, {tag, " R2 scan begins"}, int'(rd_idx), 0);
        end
        while (!done && cnt <= 3 * N + 4) begin
            start = (poke && cnt == 2) ? 1'b1 : 1'b0;
            @(negedge clk);
            cnt++;
        end
        start = 1'b0;
        check(done == 1'b1, {tag, " R7 done seen"}, int'(done), 1);
        check(cnt == elat, {tag, " R7 latency"}, cnt, elat);
        check(found == (esrc != 0), {tag, " R6 found flag"}, int'(found), int'(esrc != 0));
        check(int'(slot_src) == esrc, {tag, " R3 R4 R5 source code"}, int'(slot_src), esrc);
        if (esrc != 0) begin
            check(int'(slot_idx) == eidx, {tag, " R4 R5 slot index"}, int'(slot_idx), eidx);
        end
        hidx = int'(slot_idx); hsrc = int'(slot_src);
        @(negedge clk);
        check(done == 1'b0, {tag, " R9 pulse width"}, int'(done), 0);
        check(int'(slot_idx) == hidx && int'(slot_src) == hsrc, {tag, " R9 result held"},
              int'(slot_idx), hidx);
    endtask

    task automatic fill(input logic [3:0] c, input logic [47:0] m);
        for (int i = 0; i < N; i++) begin
            t_ctl[i] = c; t_mac[i] = m;
        end
    endtask

    initial begin
        void'($urandom(32'h5107_A11C));
        pool[0] = 48'h0012_3456_789A;
        pool[1] = 48'h0200_0000_0001;
        pool[2] = 48'h0100_5E00_00FB;   // multicast: bit 40 set
        pool[3] = 48'h00AA_BBCC_DDEE;
        fill(4'h0, '0);

        repeat (3) @(negedge clk);
        check(!busy && !done && !found && slot_src == 2'd0 && slot_idx == '0,
              "R1 reset state", int'(busy) + int'(done) + int'(found), 0);
        rst_n = 1'b1;

        // All free: first slot wins in the free pass.
        lookup(pool[0], 1'b0, '0, "all free");

        // Match at the last slot beats a free slot at index 0 (R3 over R4).
        fill(4'h1, pool[3]);
        t_ctl[0] = 4'h0;
        t_ctl[N-1] = 4'h3; t_mac[N-1] = pool[1];
        lookup(pool[1], 1'b0, '0, "R3 match last");

        // Type 2 with equal address is not a match (R3); free slot taken.
        fill(4'h1, pool[3]);
        t_ctl[1] = 4'h2; t_mac[1] = pool[0];
        t_ctl[7] = 4'h0;
        lookup(pool[0], 1'b0, '0, "R3 type2 ignored");

        // Full of protected entries: persistent, OUI, multicast touched (R5, R6).
        for (int i = 0; i < N; i++) begin
            t_ctl[i] = (i % 3 == 0) ? 4'h1 : (i % 3 == 1) ? 4'h9 : 4'hD;
            t_mac[i] = (i % 3 == 2) ? pool[2] : pool[3];
        end
        lookup(pool[0], 1'b0, '0, "R6 full");

        // Eviction: untouched multicast at 2 skipped, touched unicast at 5 chosen.
        fill(4'h1, pool[3]);
        t_ctl[2] = 4'h5; t_mac[2] = pool[2];
        t_ctl[5] = 4'hF; t_mac[5] = pool[1];
        t_ctl[9] = 4'h7; t_mac[9] = pool[1];
        lookup(pool[0], 1'b0, '0, "R5 evict");

        // Start during busy is ignored: key pool[1] would match at 4 (R8).
        fill(4'h1, pool[3]);
        t_mac[4] = pool[1];
        t_ctl[12] = 4'h0;
        lookup(pool[0], 1'b1, pool[1], "R8 ignore");

        // Constrained random tables and keys.
        for (int r = 0; r < 60; r++) begin
            logic [47:0] k;
            for (int i = 0; i < N; i++) begin
                logic [1:0] t;
                t = 2'($urandom % 4);
                if ((r % 4) != 0 && t == 2'd0) t = 2'd1;
                t_ctl[i] = {2'($urandom % 4), t};
                t_mac[i] = pool[$urandom % 4];
            end
            k = ($urandom % 5 == 4) ? {$urandom, 16'h0} : pool[$urandom % 4];
            lookup(k, (r % 5 == 0), pool[$urandom % 4], "random");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule